// File: doc/BRIEF.md
# Configurable True Dual-Port Block RAM

This block is a synchronous memory with two fully independent access ports, A and B, that share one storage array. Each port has its own clock enable, write enable, chip-select code, address, write data, local output reset and read data. Every request is sampled on the rising clock edge, and the array update and the read happen in that same edge. Each port then has an output latch, with an optional output register after it that adds one cycle of latency.

Parameters set the behaviour of each port. A port's write mode decides what its output shows on a write cycle:

- **Normal**: the output holds its value.
- **Write-through**: the output shows the new data.
- **Read-before-write**: the output shows the data the write replaces.

A port responds only when its clock enable is high and its 3-bit chip-select input matches that port's programmed code.

The output stages are cleared in two ways. A per-port reset clears only that port's stages. A global reset clears the stages of both ports. A parameter chooses whether these clears act on the clock edge or immediately.

Top module: `dpram_tdp`

## Requirements
- R1: A request is sampled on a rising clock edge. Without the output register, its read data appears on the port output after that edge and not before it.
- R2: When a port's output register is enabled, its read data appears one clock edge later than without it (two edges after the request is sampled).
- R3: In normal mode (mode code 0), a write cycle leaves the port output unchanged. Only read cycles update it.
- R4: In write-through mode (mode code 1), a write cycle presents the written data on that port's output.
- R5: In read-before-write mode (mode code 2), a write cycle presents the previous contents of the addressed word on that port's output.
- R6: A port acts only when ce is 1 and its 3-bit cs equals that port's code parameter. Otherwise nothing is written and its output holds.
- R7: If both ports write the same address in one cycle, port A's data is stored. A read on one port of an address being written by the other port returns the old contents.
- R8: A port's local reset (active high) clears that port's output latch and output register to zero and leaves the other port unaffected.
- R9: The global reset (active high) clears the output stages of both ports.
- R10: With ASYNC_RST=1 the clear takes effect immediately, without a clock edge. With ASYNC_RST=0 it takes effect at the next rising edge. Resets never alter the array contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_g | input | 1 | Global output-stage clear, active high |
| ce_a | input | 1 | Port A clock enable |
| we_a | input | 1 | Port A write enable |
| cs_a | input | CS_W | Port A chip-select value |
| addr_a | input | ADDR_W | Port A word address |
| din_a | input | DATA_W | Port A write data |
| rst_a | input | 1 | Port A local output clear, active high |
| dout_a | output | DATA_W | Port A read data |
| ce_b | input | 1 | Port B clock enable |
| we_b | input | 1 | Port B write enable |
| cs_b | input | CS_W | Port B chip-select value |
| addr_b | input | ADDR_W | Port B word address |
| din_b | input | DATA_W | Port B write data |
| rst_b | input | 1 | Port B local output clear, active high |
| dout_b | output | DATA_W | Port B read data |

## Verification
The hardest case to reach from the ports is a same-cycle interaction between the two ports. This means both ports writing one address, or one port reading a word while the other overwrites it, with the result then read back through a port whose output register delays it. The stimulus table places these collisions back to back with follow-up reads on both ports. Two instances with different mode and register choices share the same inputs, so every mode is compared against one reference array.

An asynchronous clear is driven in the middle of a clock period. The bench then samples both instances before the next edge, which separates immediate clearing from edge-timed clearing.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

   typedef enum logic [1:0] {
      WM_NORMAL  = 2'd0,
      WM_THROUGH = 2'd1,
      WM_RBW     = 2'd2
   } wmode_e;

endpackage

// File: rtl/dpram_port_ctl.sv
module dpram_port_ctl #(
   parameter int                 DATA_W  = 18,
   parameter int                 CS_W    = 3,
   parameter logic [CS_W-1:0]    CS_CODE = '0,
   parameter dpram_pkg::wmode_e  MODE    = dpram_pkg::WM_NORMAL
) (
   input  logic              ce,
   input  logic              we,
   input  logic [CS_W-1:0]   cs,
   input  logic [DATA_W-1:0] din,
   input  logic [DATA_W-1:0] rd_old,
   output logic              wr,
   output logic              load,
   output logic [DATA_W-1:0] load_val
);

   logic sel;

   assign sel = ce && (cs == CS_CODE);
   assign wr  = sel && we;

   generate
      if (MODE == dpram_pkg::WM_NORMAL) begin : g_normal
         assign load     = sel && !we;
         assign load_val = rd_old;
      end else if (MODE == dpram_pkg::WM_THROUGH) begin : g_through
         assign load     = sel;
         assign load_val = we ? din : rd_old;
      end else begin : g_rbw
         assign load     = sel;
         assign load_val = rd_old;
      end
   endgenerate

endmodule

// File: rtl/dpram_out_stage.sv
module dpram_out_stage #(
   parameter int DATA_W    = 18,
   parameter bit OUT_REG   = 1'b0,
   parameter bit ASYNC_RST = 1'b0
) (
   input  logic              clk,
   input  logic              clr,
   input  logic              load,
   input  logic [DATA_W-1:0] load_val,
   output logic [DATA_W-1:0] dout
);

   logic [DATA_W-1:0] lat;

   generate
      if (ASYNC_RST) begin : g_lat_async
         always_ff @(posedge clk or posedge clr) begin
            if (clr)       lat <= '0;
            else if (load) lat <= load_val;
         end
      end else begin : g_lat_sync
         always_ff @(posedge clk) begin
            if (clr)       lat <= '0;
            else if (load) lat <= load_val;
         end
      end

      if (OUT_REG) begin : g_oreg
         logic [DATA_W-1:0] oreg;
         if (ASYNC_RST) begin : g_oreg_async
            always_ff @(posedge clk or posedge clr) begin
               if (clr) oreg <= '0;
               else     oreg <= lat;
            end
         end else begin : g_oreg_sync
            always_ff @(posedge clk) begin
               if (clr) oreg <= '0;
               else     oreg <= lat;
            end
         end
         assign dout = oreg;

         AST_OREG_DELAY: assert property (@(posedge clk) disable iff (clr)
            !$past(clr) |-> (oreg == $past(lat)));                          // R2
      end else begin : g_direct
         assign dout = lat;
      end
   endgenerate

   AST_CLR_ZERO: assert property (@(posedge clk)
      clr |=> (lat == '0));                                                 // R8

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (clr)
      (!clr && !load) |=> (lat == $past(lat)));                             // R6

endmodule

// File: rtl/dpram_tdp.sv
module dpram_tdp #(
   parameter int                 ADDR_W    = 8,
   parameter int                 DATA_W    = 18,
   parameter int                 CS_W      = 3,
   parameter logic [CS_W-1:0]    CS_CODE_A = 3'd1,
   parameter logic [CS_W-1:0]    CS_CODE_B = 3'd2,
   parameter dpram_pkg::wmode_e  MODE_A    = dpram_pkg::WM_NORMAL,
   parameter dpram_pkg::wmode_e  MODE_B    = dpram_pkg::WM_NORMAL,
   parameter bit                 OUT_REG_A = 1'b0,
   parameter bit                 OUT_REG_B = 1'b0,
   parameter bit                 ASYNC_RST = 1'b0
) (
   input  logic              clk,
   input  logic              rst_g,
   input  logic              ce_a,
   input  logic              we_a,
   input  logic [CS_W-1:0]   cs_a,
   input  logic [ADDR_W-1:0] addr_a,
   input  logic [DATA_W-1:0] din_a,
   input  logic              rst_a,
   output logic [DATA_W-1:0] dout_a,
   input  logic              ce_b,
   input  logic              we_b,
   input  logic [CS_W-1:0]   cs_b,
   input  logic [ADDR_W-1:0] addr_b,
   input  logic [DATA_W-1:0] din_b,
   input  logic              rst_b,
   output logic [DATA_W-1:0] dout_b
);

   localparam int DEPTH  = 1 << ADDR_W;
   localparam int NPORTS = 2;

   generate
      if (ADDR_W < 1 || ADDR_W > 13) begin : g_bad_addr_w
         $error("dpram_tdp: ADDR_W must lie in 1..13");
      end
      if (DATA_W < 1 || DATA_W > 36) begin : g_bad_data_w
         $error("dpram_tdp: DATA_W must lie in 1..36");
      end
      if (CS_W != 3) begin : g_bad_cs_w
         $error("dpram_tdp: CS_W must be 3");
      end
   endgenerate

   logic [DATA_W-1:0] mem [DEPTH];

   logic [NPORTS-1:0] ce_v, we_v, clr_v, wr_v, load_v;
   logic [CS_W-1:0]   cs_v     [NPORTS];
   logic [ADDR_W-1:0] addr_v   [NPORTS];
   logic [DATA_W-1:0] din_v    [NPORTS];
   logic [DATA_W-1:0] rd_old   [NPORTS];
   logic [DATA_W-1:0] load_val [NPORTS];
   logic [DATA_W-1:0] dout_v   [NPORTS];

   assign ce_v   = {ce_b, ce_a};
   assign we_v   = {we_b, we_a};
   assign clr_v  = {rst_b | rst_g, rst_a | rst_g};
   assign cs_v   = '{cs_a, cs_b};
   assign addr_v = '{addr_a, addr_b};
   assign din_v  = '{din_a, din_b};
   assign dout_a = dout_v[0];
   assign dout_b = dout_v[1];

   // Port B is written first so that port A's write wins on a shared address.
   always_ff @(posedge clk) begin
      if (wr_v[1]) mem[addr_v[1]] <= din_v[1];
      if (wr_v[0]) mem[addr_v[0]] <= din_v[0];
   end

   for (genvar p = 0; p < NPORTS; p++) begin : g_port
      localparam logic [CS_W-1:0]   CODE = (p == 0) ? CS_CODE_A : CS_CODE_B;
      localparam dpram_pkg::wmode_e MODE = (p == 0) ? MODE_A    : MODE_B;
      localparam bit                OREG = (p == 0) ? OUT_REG_A : OUT_REG_B;

      assign rd_old[p] = mem[addr_v[p]];

      dpram_port_ctl #(
         .DATA_W (DATA_W),
         .CS_W   (CS_W),
         .CS_CODE(CODE),
         .MODE   (MODE)
      ) u_ctl (
         .ce      (ce_v[p]),
         .we      (we_v[p]),
         .cs      (cs_v[p]),
         .din     (din_v[p]),
         .rd_old  (rd_old[p]),
         .wr      (wr_v[p]),
         .load    (load_v[p]),
         .load_val(load_val[p])
      );

      dpram_out_stage #(
         .DATA_W   (DATA_W),
         .OUT_REG  (OREG),
         .ASYNC_RST(ASYNC_RST)
      ) u_out (
         .clk     (clk),
         .clr     (clr_v[p]),
         .load    (load_v[p]),
         .load_val(load_val[p]),
         .dout    (dout_v[p])
      );

      if (!OREG && MODE == dpram_pkg::WM_THROUGH) begin : g_chk_through
         AST_THROUGH_ECHO: assert property (@(posedge clk) disable iff (clr_v[p])
            (ce_v[p] && we_v[p] && cs_v[p] == CODE) |=> (dout_v[p] == $past(din_v[p])));  // R4
      end
      if (!OREG && MODE == dpram_pkg::WM_NORMAL) begin : g_chk_normal
         AST_NORMAL_HOLD: assert property (@(posedge clk) disable iff (clr_v[p])
            (ce_v[p] && we_v[p]) |=> $stable(dout_v[p]));                                  // R3
      end
   end

   AST_PORT_A_WINS: assert property (@(posedge clk) disable iff (rst_g)
      (wr_v[0] && wr_v[1] && addr_v[0] == addr_v[1]) |=>
         (mem[$past(addr_v[0])] == $past(din_v[0])));                                     // R7

endmodule

// File: tb/dpram_tdp_test.sv
`timescale 1ns/1ps
module dpram_tdp_test;
   import dpram_pkg::*;

   localparam int AW = 4;
   localparam int DW = 18;
   localparam logic [2:0] CA = 3'd5;
   localparam logic [2:0] CB = 3'd2;
   localparam int VW = 2 * (1 + 1 + 3 + AW + DW) + 4;
   localparam int NV = 15;

   // {ceA,weA,csA,addrA,dinA, ceB,weB,csB,addrB,dinB, tag}
   localparam logic [VW-1:0] VEC [NV] = '{
      {1'b1,1'b0,CA,4'd1,18'h0, 1'b1,1'b0,CB,4'd2,18'h0,      4'd1},  // R1 plain reads
      {1'b1,1'b1,CA,4'd3,18'h01111, 1'b0,1'b0,CB,4'd0,18'h0,  4'd3},  // R3 R5 write A
      {1'b1,1'b0,CA,4'd3,18'h0, 1'b1,1'b1,CB,4'd4,18'h02222,  4'd4},  // R4 write B
      {1'b1,1'b1,CA,4'd5,18'h0AAAA, 1'b1,1'b0,CB,4'd5,18'h0,  4'd7},  // R7 cross read old
      {1'b1,1'b1,CA,4'd6,18'h3A3A3, 1'b1,1'b1,CB,4'd6,18'h0B0B0, 4'd7},  // R7 collision
      {1'b1,1'b0,CA,4'd6,18'h0, 1'b1,1'b0,CB,4'd6,18'h0,      4'd7},  // R7 readback
      {1'b1,1'b1,3'd4,4'd7,18'h3FFFF, 1'b0,1'b0,CB,4'd0,18'h0, 4'd6}, // R6 cs mismatch
      {1'b1,1'b0,CA,4'd7,18'h0, 1'b1,1'b0,CB,4'd5,18'h0,      4'd6},  // R6 readback
      {1'b0,1'b0,CA,4'd0,18'h0, 1'b0,1'b1,CB,4'd8,18'h12345,  4'd6},  // R6 ce low
      {1'b1,1'b0,CA,4'd4,18'h0, 1'b1,1'b0,CB,4'd8,18'h0,      4'd6},  // R6 readback
      {1'b0,1'b0,CA,4'd0,18'h0, 1'b0,1'b0,CB,4'd0,18'h0,      4'd2},  // R2 idle drain
      {1'b1,1'b1,CA,4'd9,18'h00F0F, 1'b1,1'b1,CB,4'd10,18'h0F0F0, 4'd5}, // R5 both write
      {1'b1,1'b0,CA,4'd10,18'h0, 1'b1,1'b0,CB,4'd9,18'h0,     4'd5},  // R5 readback
      {1'b0,1'b0,CA,4'd0,18'h0, 1'b1,1'b1,CA,4'd9,18'h15555,  4'd6},  // R6 B with A's code
      {1'b1,1'b0,CA,4'd9,18'h0, 1'b1,1'b0,CB,4'd9,18'h0,      4'd6}   // R6 readback
   };

   localparam wmode_e MD  [4] = '{WM_NORMAL, WM_THROUGH, WM_RBW, WM_RBW};
   localparam bit     ORG [4] = '{1'b0, 1'b1, 1'b1, 1'b0};

   logic          clk = 1'b0;
   logic          grst;
   logic          ce  [2];
   logic          we  [2];
   logic [2:0]    cs  [2];
   logic [AW-1:0] ad  [2];
   logic [DW-1:0] di  [2];
   logic          lrst[2];
   logic [DW-1:0] dout_w [4];

   logic [DW-1:0] ref_mem [16];
   logic [DW-1:0] m_lat [4];
   logic [DW-1:0] m_reg [4];
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   dpram_tdp #(.ADDR_W(AW), .DATA_W(DW), .CS_W(3), .CS_CODE_A(CA), .CS_CODE_B(CB),
      .MODE_A(WM_NORMAL), .MODE_B(WM_THROUGH), .OUT_REG_A(1'b0), .OUT_REG_B(1'b1),
      .ASYNC_RST(1'b0)) uut (
      .clk(clk), .rst_g(grst),
      .ce_a(ce[0]), .we_a(we[0]), .cs_a(cs[0]), .addr_a(ad[0]), .din_a(di[0]),
      .rst_a(lrst[0]), .dout_a(dout_w[0]),
      .ce_b(ce[1]), .we_b(we[1]), .cs_b(cs[1]), .addr_b(ad[1]), .din_b(di[1]),
      .rst_b(lrst[1]), .dout_b(dout_w[1]));

   dpram_tdp #(.ADDR_W(AW), .DATA_W(DW), .CS_W(3), .CS_CODE_A(CA), .CS_CODE_B(CB),
      .MODE_A(WM_RBW), .MODE_B(WM_RBW), .OUT_REG_A(1'b1), .OUT_REG_B(1'b0),
      .ASYNC_RST(1'b1)) uut2 (
      .clk(clk), .rst_g(grst),
      .ce_a(ce[0]), .we_a(we[0]), .cs_a(cs[0]), .addr_a(ad[0]), .din_a(di[0]),
      .rst_a(lrst[0]), .dout_a(dout_w[2]),
      .ce_b(ce[1]), .we_b(we[1]), .cs_b(cs[1]), .addr_b(ad[1]), .din_b(di[1]),
      .rst_b(lrst[1]), .dout_b(dout_w[3]));

   task automatic check(input int p, input logic [DW-1:0] exp, input int tag);
      checks++;
      if (dout_w[p] !== exp) begin
         errors++;
         $display("FAIL R%0d port %0d actual %h expected %h", tag, p, dout_w[p], exp);
      end
   endtask

   function automatic logic [DW-1:0] model_out(input int p);
      return ORG[p] ? m_reg[p] : m_lat[p];
   endfunction

   // Reference update for one rising edge, from the requirements.
   task automatic model_edge();
      logic          act [2];
      logic [DW-1:0] rd  [2];
      for (int s = 0; s < 2; s++) begin
         act[s] = ce[s] && (cs[s] == ((s == 0) ? CA : CB));
         rd[s]  = ref_mem[ad[s]];
      end
      for (int p = 0; p < 4; p++) begin
         int s;
         logic [DW-1:0] nl;
         s  = p % 2;
         nl = m_lat[p];
         if (act[s]) begin
            if (!we[s])                 nl = rd[s];
            else if (MD[p] == WM_THROUGH) nl = di[s];
            else if (MD[p] == WM_RBW)     nl = rd[s];
         end
         m_reg[p] = m_lat[p];
         m_lat[p] = nl;
         if (lrst[s] || grst) begin
            m_lat[p] = '0;
            m_reg[p] = '0;
         end
      end
      if (act[1] && we[1]) ref_mem[ad[1]] = di[1];
      if (act[0] && we[0]) ref_mem[ad[0]] = di[0];
   endtask

   task automatic drive(input logic [VW-1:0] v);
      {ce[0], we[0], cs[0], ad[0], di[0], ce[1], we[1], cs[1], ad[1], di[1]} = v[VW-1:4];
   endtask

   task automatic step_check(input int tag);
      @(posedge clk);
      #1;
      model_edge();
      @(negedge clk);
      for (int p = 0; p < 4; p++) check(p, model_out(p), tag);
   endtask

   initial begin
      #(8 * 20000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      grst = 1'b1;
      for (int s = 0; s < 2; s++) begin
         ce[s] = 0; we[s] = 0; cs[s] = 0; ad[s] = 0; di[s] = 0; lrst[s] = 0;
      end
      for (int p = 0; p < 4; p++) begin m_lat[p] = '0; m_reg[p] = '0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      for (int p = 0; p < 4; p++) check(p, '0, 9);    // R9 reset state
      grst = 1'b0;

      // preload every word through port A
      for (int a = 0; a < 16; a++) begin
         drive({1'b1,1'b1,CA,4'(a),18'(a * 3 + 1), 1'b0,1'b0,CB,4'd0,18'h0, 4'd0});
         @(posedge clk); #1; model_edge(); @(negedge clk);
      end

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i]);
         step_check(int'(VEC[i][3:0]));
      end

      // R1: read request is not visible before its edge
      drive({1'b1,1'b0,CA,4'd11,18'h0, 1'b0,1'b0,CB,4'd0,18'h0, 4'd1});
      #2;
      check(0, model_out(0), 1);                      // R1 before edge
      step_check(1);                                  // R1 after edge
      drive({1'b0,1'b0,CA,4'd0,18'h0, 1'b0,1'b0,CB,4'd0,18'h0, 4'd0});
      step_check(2);                                  // R2 register catches up

      // R8: local clear on port A only
      lrst[0] = 1'b1;
      step_check(8);
      lrst[0] = 1'b0;
      drive({1'b1,1'b0,CA,4'd6,18'h0, 1'b1,1'b0,CB,4'd9,18'h0, 4'd0});
      step_check(10);                                 // R10 array kept
      step_check(2);

      // R10: asynchronous clear on port B between edges
      #1;
      lrst[1] = 1'b1;
      #1;
      check(3, '0, 10);                               // R10 async clears now
      check(1, model_out(1), 10);                     // R10 sync waits for edge
      step_check(8);                                  // R8 port B cleared, A kept
      lrst[1] = 1'b0;

      // R9: global clear, then the array still reads back
      grst = 1'b1;
      step_check(9);
      grst = 1'b0;
      drive({1'b1,1'b0,CA,4'd9,18'h0, 1'b1,1'b0,CB,4'd6,18'h0, 4'd0});
      step_check(10);
      step_check(10);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule